// File: doc/BRIEF.md
# Additive Harmonic Tone Synthesizer

The block turns a bitmap of held keys into one mono audio sample each time a sample-ready pulse arrives. Each of the 38 keys has a fundamental pitch on a semitone scale. For every key the block takes the fundamental and four overtones. It looks up a sine amplitude for each one at the current time step and weights it by a coefficient that depends on the selected timbre. It then sums the weighted amplitudes of all held keys into one sample.

Work is streamed rather than done one request at a time. After a ready pulse, a sequencer issues 190 phase requests, one per clock cycle. They are ordered by harmonic first and by key within each harmonic. Each request flows through a fixed-latency pipeline: a frequency-by-time product, a pipelined restoring remainder against the table length, and a registered sine-table read. Results come out in request order, one per cycle. They are gated by the key bitmap and added into a wide accumulator. The output sample register changes only once the last result has been absorbed, so a consumer sees a stable value between updates.

Top module: `tone_synth`

## Requirements
- R1: After synchronous reset, `sample` is 0 and the internal time step is 0.
- R2: Every cycle in which `ready` is high advances the time step by one, and 48000 steps to 0. The sample computed after that pulse uses the new step value.
- R3: After a ready pulse, exactly 190 requests are issued on consecutive cycles. The first is key 0, harmonic 0. The key index runs 0..37 inside each harmonic, and the harmonics run 0..4. Issuing stops after the last request.
- R4: Key n has the integer base frequency in Hz from the semitone table: 93 Hz at n=0, 440 Hz at n=27 and 784 Hz at n=37. Harmonic k (0..4) uses (k+1) times the base.
- R5: The table address is ((frequency × step) >> 6) mod 750. Table entry i is round(32767·sin(2πi/750)) as a signed 16-bit value.
- R6: Each signed amplitude is multiplied by a signed 9-bit coefficient. It is added to the sum only when bit n of `notes` is set, where bit n means key n.
- R7: The `timbre` codes select these coefficients for harmonics 0..4: 0 gives FF,0,0,0,0; 1 gives 64,63,1F,19,0; 2 gives CC,0,33,0,0; 3 gives 33 on all five (hex).
- R8: The sum is kept modulo 2^27. `sample` is bits 26:7 of it. `sample` holds its value until all 190 results of a pulse have been absorbed.
- R9: A ready pulse arriving mid-computation abandons the work in flight. Only the new pulse's sample, built from the key bitmap and timbre at that time, is produced.
- R10: With no key bit set, the produced sample is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ready | input | 1 | Sample-ready pulse; starts a new sample |
| notes | input | 38 | Held-key bitmap, bit n = key n |
| timbre | input | 2 | Coefficient set select |
| sample | output | 20 | Signed output sample, two's complement |

## Verification
The block is tried with one key under the pure timbre, a sparse chord spread across the range, and high keys under the two-overtone timbre. It is also tried with every key held under the flat timbre, so that the accumulator wraps, and with an empty bitmap. Together these tell apart errors in the frequency table, the harmonic multiple, the coefficient that lines up with each returned result, bitmap gating, and accumulator width. Consecutive pulses and a long pulse train past 48000 steps expose time-step counting and its wrap. Reading `sample` partway through a computation and re-pulsing mid-stream separate a correct hold and abandon from leakage of partial sums.

// File: rtl/synth_pkg.sv
package synth_pkg;
    localparam int NUM_NOTES   = 38;
    localparam int NUM_HARM    = 5;
    localparam int TABLE_LEN   = 750;
    localparam int STEP_MAX    = 48000;
    localparam int PHASE_SHIFT = 6;
    localparam int FREQ_W      = 12;
    localparam int AMP_W       = 16;
    localparam int COEF_W      = 9;
    localparam int ACC_W       = 27;
    localparam int OUT_W       = 20;
    localparam int AMP_PEAK    = 32767;

    localparam int STEP_W  = $clog2(STEP_MAX + 1);
    localparam int NOTE_W  = $clog2(NUM_NOTES);
    localparam int HARM_W  = $clog2(NUM_HARM);
    localparam int ADDR_W  = $clog2(TABLE_LEN);
    localparam int PHASE_W = FREQ_W + STEP_W - PHASE_SHIFT;

    typedef logic [FREQ_W-1:0] freq_t;
    typedef logic [STEP_W-1:0] step_t;

    typedef struct packed {
        logic              valid;
        logic              last;
        logic [NOTE_W-1:0] note;
        logic [HARM_W-1:0] harm;
    } tag_t;

    typedef enum logic [1:0] {
        TIMBRE_PURE  = 2'd0,
        TIMBRE_PLUCK = 2'd1,
        TIMBRE_BELL  = 2'd2,
        TIMBRE_REED  = 2'd3
    } timbre_e;

    localparam int unsigned BASE_HZ [NUM_NOTES] = '{
        93, 98, 104, 110, 117, 123, 131, 139, 147, 156,
        165, 175, 185, 196, 208, 220, 233, 247, 262, 277,
        294, 311, 330, 349, 370, 392, 415, 440, 466, 494,
        523, 554, 587, 622, 659, 698, 740, 784
    };

    function automatic freq_t note_freq(input logic [NOTE_W-1:0] n,
                                        input logic [HARM_W-1:0] h);
        if (int'(n) >= NUM_NOTES) return '0;
        return freq_t'(BASE_HZ[n] * (int'(h) + 1));
    endfunction

    function automatic logic signed [COEF_W-1:0] harm_coef(input timbre_e sel,
                                                           input logic [HARM_W-1:0] h);
        logic [7:0] c;
        int k;
        k = int'(h);
        c = 8'h00;
        case (sel)
            TIMBRE_PURE:  c = (k == 0) ? 8'hFF : 8'h00;
            TIMBRE_PLUCK: begin
                if (k == 0)      c = 8'h64;
                else if (k == 1) c = 8'h63;
                else if (k == 2) c = 8'h1F;
                else if (k == 3) c = 8'h19;
            end
            TIMBRE_BELL:  c = (k == 0) ? 8'hCC : ((k == 2) ? 8'h33 : 8'h00);
            default:      c = (k < NUM_HARM) ? 8'h33 : 8'h00;
        endcase
        return {1'b0, c};
    endfunction

    function automatic logic signed [AMP_W-1:0] sine_entry(input int i);
        real ph;
        ph = 2.0 * 3.14159265358979 * real'(i) / real'(TABLE_LEN);
        return AMP_W'(int'($sin(ph) * real'(AMP_PEAK)));
    endfunction
endpackage

// File: rtl/synth_seq.sv
module synth_seq
    import synth_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  ready,
    output tag_t  req_tag,
    output freq_t req_freq,
    output step_t step
);
    logic              sending;
    logic [NOTE_W-1:0] note;
    logic [HARM_W-1:0] harm;
    logic              note_end;
    logic              at_last;

    assign note_end = (int'(note) == NUM_NOTES - 1);
    assign at_last  = note_end && (int'(harm) == NUM_HARM - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            sending <= 1'b0;
            note    <= '0;
            harm    <= '0;
            step    <= '0;
        end else if (ready) begin
            sending <= 1'b1;
            note    <= '0;
            harm    <= '0;
            step    <= (step == step_t'(STEP_MAX)) ? '0 : step + 1'b1;
        end else if (sending) begin
            if (at_last) sending <= 1'b0;
            if (note_end) begin
                note <= '0;
                harm <= harm + 1'b1;
            end else begin
                note <= note + 1'b1;
            end
        end
    end

    assign req_tag  = '{valid: sending, last: sending && at_last, note: note, harm: harm};
    assign req_freq = note_freq(note, harm);
endmodule

// File: rtl/phase_mod_pipe.sv
module phase_mod_pipe
    import synth_pkg::*;
#(
    parameter  int DIVISOR = TABLE_LEN,
    parameter  int IN_W    = PHASE_W,
    localparam int DIV_W   = $clog2(DIVISOR),
    localparam int STAGES  = IN_W - DIV_W + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  tag_t             in_tag,
    input  freq_t            in_freq,
    input  step_t            in_step,
    output tag_t             out_tag,
    output logic [DIV_W-1:0] out_rem
);
    logic [FREQ_W+STEP_W-1:0] prod_full;
    tag_t                     tg [STAGES+1];
    logic [IN_W-1:0]          rm [STAGES+1];
    tag_t                     tg0_q;
    logic [IN_W-1:0]          rm0_q;

    assign prod_full = in_freq * in_step;

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            tg0_q <= '0;
            rm0_q <= '0;
        end else begin
            tg0_q <= in_tag;
            rm0_q <= IN_W'(prod_full >> PHASE_SHIFT);
        end
    end
    assign tg[0] = tg0_q;
    assign rm[0] = rm0_q;

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        localparam logic [IN_W-1:0] TRIAL = IN_W'(DIVISOR) << (STAGES - 1 - s);
        tag_t            tg_q;
        logic [IN_W-1:0] rm_q;
        always_ff @(posedge clk) begin
            if (rst || flush) begin
                tg_q <= '0;
                rm_q <= '0;
            end else begin
                tg_q <= tg[s];
                rm_q <= (rm[s] >= TRIAL) ? rm[s] - TRIAL : rm[s];
            end
        end
        assign tg[s+1] = tg_q;
        assign rm[s+1] = rm_q;
    end

    assign out_tag = tg[STAGES];
    assign out_rem = DIV_W'(rm[STAGES]);
endmodule

// File: rtl/sine_rom.sv
module sine_rom
    import synth_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    flush,
    input  tag_t                    in_tag,
    input  logic [ADDR_W-1:0]       addr,
    output tag_t                    out_tag,
    output logic signed [AMP_W-1:0] amp
);
    logic signed [AMP_W-1:0] table_w [TABLE_LEN];

    for (genvar i = 0; i < TABLE_LEN; i++) begin : g_entry
        localparam logic signed [AMP_W-1:0] VAL = sine_entry(i);
        assign table_w[i] = VAL;
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            out_tag <= '0;
            amp     <= '0;
        end else begin
            out_tag <= in_tag;
            amp     <= (int'(addr) < TABLE_LEN) ? table_w[addr] : '0;
        end
    end
endmodule

// File: rtl/harm_accum.sv
module harm_accum
    import synth_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    ready,
    input  tag_t                    in_tag,
    input  logic signed [AMP_W-1:0] amp,
    input  logic [NUM_NOTES-1:0]    notes,
    input  timbre_e                 timbre,
    output logic [OUT_W-1:0]        sample
);
    logic signed [COEF_W-1:0]       coef;
    logic signed [AMP_W+COEF_W-1:0] prod;
    logic signed [ACC_W-1:0]        acc;
    logic signed [ACC_W-1:0]        acc_next;

    assign coef     = harm_coef(timbre, in_tag.harm);
    assign prod     = amp * coef;
    assign acc_next = acc + (notes[in_tag.note] ? ACC_W'(prod) : '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            acc    <= '0;
            sample <= '0;
        end else if (ready) begin
            acc <= '0;
        end else if (in_tag.valid) begin
            acc <= acc_next;
            if (in_tag.last) sample <= acc_next[ACC_W-1:ACC_W-OUT_W];
        end
    end
endmodule

// File: rtl/tone_synth.sv
module tone_synth
    import synth_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 ready,
    input  logic [NUM_NOTES-1:0] notes,
    input  logic [1:0]           timbre,
    output logic [OUT_W-1:0]     sample
);
    tag_t                    req_tag;
    freq_t                   req_freq;
    step_t                   step;
    tag_t                    rem_tag;
    logic [ADDR_W-1:0]       rem_val;
    tag_t                    amp_tag;
    logic signed [AMP_W-1:0] amp_val;

    synth_seq u_seq (
        .clk(clk), .rst(rst), .ready(ready),
        .req_tag(req_tag), .req_freq(req_freq), .step(step)
    );

    phase_mod_pipe #(.DIVISOR(TABLE_LEN), .IN_W(PHASE_W)) u_mod (
        .clk(clk), .rst(rst), .flush(ready),
        .in_tag(req_tag), .in_freq(req_freq), .in_step(step),
        .out_tag(rem_tag), .out_rem(rem_val)
    );

    sine_rom u_rom (
        .clk(clk), .rst(rst), .flush(ready),
        .in_tag(rem_tag), .addr(rem_val),
        .out_tag(amp_tag), .amp(amp_val)
    );

    harm_accum u_acc (
        .clk(clk), .rst(rst), .ready(ready),
        .in_tag(amp_tag), .amp(amp_val), .notes(notes),
        .timbre(timbre_e'(timbre)), .sample(sample)
    );
endmodule

// File: rtl/synth_checks.sv
module synth_checks
    import synth_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              ready,
    input tag_t              req_tag,
    input step_t             step,
    input tag_t              rem_tag,
    input logic [ADDR_W-1:0] rem_val,
    input tag_t              amp_tag,
    input logic [OUT_W-1:0]  sample
);
    a_r3_start: assert property (@(posedge clk) disable iff (rst)
        ready |=> (req_tag.valid && req_tag.note == '0 && req_tag.harm == '0));

    a_r3_stop: assert property (@(posedge clk) disable iff (rst)
        (req_tag.last && !ready) |=> !req_tag.valid);

    a_r3_order: assert property (@(posedge clk) disable iff (rst)
        (req_tag.valid && !req_tag.last && !ready) |=> (req_tag.valid &&
        ((req_tag.note == $past(req_tag.note) + 1'b1 && req_tag.harm == $past(req_tag.harm)) ||
         (int'($past(req_tag.note)) == NUM_NOTES - 1 && req_tag.note == '0 &&
          req_tag.harm == $past(req_tag.harm) + 1'b1))));

    a_r2_step_range: assert property (@(posedge clk) disable iff (rst)
        int'(step) <= STEP_MAX);

    a_r2_step_wrap: assert property (@(posedge clk) disable iff (rst)
        (ready && int'(step) == STEP_MAX) |=> step == '0);

    a_r5_addr_range: assert property (@(posedge clk) disable iff (rst)
        rem_tag.valid |-> int'(rem_val) < TABLE_LEN);

    a_r9_flush: assert property (@(posedge clk) disable iff (rst)
        ready |=> (!rem_tag.valid && !amp_tag.valid));

    a_r8_hold: assert property (@(posedge clk) disable iff (rst)
        !(amp_tag.valid && amp_tag.last) |=> $stable(sample));
endmodule

bind tone_synth synth_checks u_chk (
    .clk(clk), .rst(rst), .ready(ready), .req_tag(req_tag), .step(step),
    .rem_tag(rem_tag), .rem_val(rem_val), .amp_tag(amp_tag), .sample(sample)
);

// File: tb/tone_synth_test.sv
module tone_synth_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ready = 1'b0;
    logic [37:0] notes = '0;
    logic [1:0]  timbre = 2'd0;
    logic [19:0] sample;

    int checks = 0;
    int errors = 0;
    int t_model = 0;
    logic [19:0] last_exp = '0;

    localparam int HZ [38] = '{
        93, 98, 104, 110, 117, 123, 131, 139, 147, 156,
        165, 175, 185, 196, 208, 220, 233, 247, 262, 277,
        294, 311, 330, 349, 370, 392, 415, 440, 466, 494,
        523, 554, 587, 622, 659, 698, 740, 784
    };

    always #5 clk = ~clk;

    tone_synth uut (
        .clk(clk), .rst(rst), .ready(ready),
        .notes(notes), .timbre(timbre), .sample(sample)
    );

    function automatic int coef_of(input int sel, input int h);
        case (sel)
            0: return (h == 0) ? 255 : 0;
            1: begin
                case (h)
                    0: return 100;
                    1: return 99;
                    2: return 31;
                    3: return 25;
                    default: return 0;
                endcase
            end
            2: return (h == 0) ? 204 : ((h == 2) ? 51 : 0);
            default: return 51;
        endcase
    endfunction

    function automatic longint sine_of(input int i);
        return longint'(int'($sin(2.0 * 3.14159265358979 * real'(i) / 750.0) * 32767.0));
    endfunction

    function automatic logic [19:0] model(input logic [37:0] nb, input int sel, input int t);
        longint acc;
        logic [63:0] bits;
        acc = 0;
        for (int h = 0; h < 5; h++) begin
            for (int n = 0; n < 38; n++) begin
                if (nb[n]) begin
                    longint f, a;
                    f = longint'(HZ[n] * (h + 1));
                    a = ((f * t) >>> 6) % 750;
                    acc += sine_of(int'(a)) * coef_of(sel, h);
                end
            end
        end
        bits = acc;
        return bits[26:7];
    endfunction

    task automatic check(input string req, input logic [19:0] got, input logic [19:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: sample=%h expected=%h", req, got, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk) rst = 1'b1;
        ready = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_model = 0;
        last_exp = '0;
    endtask

    task automatic pulse();
        @(negedge clk) ready = 1'b1;
        @(negedge clk) ready = 1'b0;
        t_model = (t_model == 48000) ? 0 : t_model + 1;
    endtask

    task automatic run_sample(input string req, input logic [37:0] nb, input int sel);
        notes = nb;
        timbre = 2'(sel);
        pulse();
        repeat (260) @(negedge clk);
        last_exp = model(nb, sel, t_model);
        check(req, sample, last_exp);
    endtask

    task automatic t_reset();
        do_reset();
        check("R1 reset", sample, 20'h0);
    endtask

    task automatic t_single();
        logic [37:0] nb;
        nb = '0;
        nb[27] = 1'b1;
        run_sample("R4 R5 R7 pure single key", nb, 0);
        run_sample("R2 next step single key", nb, 0);
    endtask

    task automatic t_chord();
        logic [37:0] nb;
        nb = '0;
        nb[0] = 1'b1; nb[12] = 1'b1; nb[37] = 1'b1;
        run_sample("R6 R7 pluck chord", nb, 1);
    endtask

    task automatic t_bell();
        logic [37:0] nb;
        nb = '0;
        nb[20] = 1'b1; nb[36] = 1'b1; nb[37] = 1'b1;
        run_sample("R4 R7 bell high keys", nb, 2);
    endtask

    task automatic t_all();
        run_sample("R8 reed all keys wrap", '1, 3);
        run_sample("R8 reed all keys next", '1, 3);
    endtask

    task automatic t_empty();
        run_sample("R10 empty bitmap", '0, 1);
        check("R10 empty is zero", sample, 20'h0);
    endtask

    task automatic t_hold();
        logic [37:0] nb;
        logic [19:0] prev;
        nb = '0;
        nb[5] = 1'b1; nb[30] = 1'b1;
        run_sample("R8 setup", nb, 1);
        prev = last_exp;
        nb[9] = 1'b1;
        notes = nb;
        pulse();
        repeat (100) @(negedge clk);
        check("R8 held mid-computation", sample, prev);
        repeat (160) @(negedge clk);
        check("R8 updated after all results", sample, model(nb, 1, t_model));
    endtask

    task automatic t_restart();
        logic [37:0] na, nb2;
        na = '0; na[3] = 1'b1; na[15] = 1'b1;
        nb2 = '0; nb2[33] = 1'b1;
        notes = na;
        timbre = 2'd3;
        pulse();
        repeat (60) @(negedge clk);
        notes = nb2;
        timbre = 2'd1;
        pulse();
        repeat (260) @(negedge clk);
        check("R9 restart discards old stream", sample, model(nb2, 1, t_model));
    endtask

    task automatic t_wrap();
        logic [37:0] nb;
        do_reset();
        nb = '0;
        nb[5] = 1'b1;
        notes = nb;
        timbre = 2'd0;
        @(negedge clk) ready = 1'b1;
        repeat (48000) @(negedge clk);
        ready = 1'b0;
        t_model = 48000;
        repeat (260) @(negedge clk);
        check("R2 step at 48000", sample, model(nb, 0, 48000));
        pulse();
        repeat (260) @(negedge clk);
        check("R2 step wraps to 0", sample, model(nb, 0, 0));
    endtask

    initial begin
        t_reset();
        t_single();
        t_chord();
        t_bell();
        t_all();
        t_empty();
        t_hold();
        t_restart();
        t_wrap();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: run did not end, actual=hung expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule